// File: doc/BRIEF.md
# Cache SRAM Power Controller with Write Key and Power-Up Sequencing

This block is a small memory-mapped control unit that sets the power state of a cache SRAM partition. It also gates the cache enable so that the cache can only be switched on once the SRAM has finished powering up. Software reaches it over a simple register bus with address, write data, write strobe and read strobe. Read data comes back one clock after the read strobe. The power register is protected: a write changes it only if the upper half-word carries a fixed key.

When the SRAM is switched into the fully-on state, a delay counter in a separate slow clock domain must count a programmable number of slow cycles. Only then is the SRAM declared ready. The two domains talk through a four-phase request/acknowledge handshake over two-flop synchronizers. Two kinds of request are refused: enabling the cache while the SRAM is not on and ready, and powering the SRAM down while the cache is enabled. Each refused request sets a sticky sequence-error flag, which software can read and clear.

Register offsets from `BASE_ADDR`: power control at 0x00, cache control at 0x04, power-up delay at 0x08.

Top module: `cache_pwr_ctrl`

## Requirements
- R1: After reset, offset 0x00 reads 0xFA050003, offset 0x04 reads 0x4, offset 0x08 reads the default delay (8). Also after reset, `pwr_mode_o` is 3, `sram_ready_o` is 1, and `cache_en_o` and `seq_err_o` are 0.
- R2: A write to 0x00 updates the power mode (bits [1:0]) only when write data bits [31:16] equal 0x05FA. Any other key leaves the mode unchanged.
- R3: Reads of 0x00 return 0xFA05 in bits [31:16] and zero in bits [15:2], whatever was written. Bits [1:0] give the mode: 0 off, 2 retained, 3 on.
- R4: A keyed write of mode value 1 (reserved) is ignored, and the previous mode stays.
- R5: When the mode is not 3, `sram_ready_o` is 0 from the next clock on.
- R6: After each entry into mode 3, `sram_ready_o` rises no sooner than the programmed delay, counted in slow-clock cycles. The count restarts on every entry, even if an earlier power-up was cut short.
- R7: Writing 1 to bit 0 of 0x04 while the mode is 3 and the SRAM is ready sets `cache_en_o`. Reads of 0x04 return enable in bit 0, sequence error in bit 1 and ready in bit 2. Writing 0 to bit 0 clears the enable.
- R8: An enable request while the mode is not 3 or the SRAM is not ready keeps `cache_en_o` at 0 and sets the sticky `seq_err_o`. Writing 1 to bit 1 of 0x04 clears the flag.
- R9: A keyed write of a mode other than 3 while `cache_en_o` is 1 is refused. The mode stays 3 and `seq_err_o` is set.
- R10: Offset 0x08 holds the power-up delay in bits [15:0]. It is readable and writable, and R6 uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| slow_clk_i | input | 1 | Slow clock for the power-up delay counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Bus address |
| wdata_i | input | 32 | Bus write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one clock after `re_i` |
| pwr_mode_o | output | 2 | Power mode request to the SRAM partition |
| sram_ready_o | output | 1 | SRAM powered up and usable |
| cache_en_o | output | 1 | Cache enable |
| seq_err_o | output | 1 | Sticky sequence-error flag |

## Verification
On every clock, the assertions check several invariants: the enable only ever stands with the SRAM on and ready, ready drops once the mode leaves on, the reserved mode never appears, unkeyed writes never move the mode, a refused power-down keeps the mode on, and the error flag stays set until it is cleared. Some behaviour only the bench scenarios can show: the read-back format of each register, the lower bound on the power-up time measured in slow cycles, the restart of that delay after an interrupted power-up, and the full power-off/power-on sequence with its refusals.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_RSVD = 2'd1,
    PM_RET  = 2'd2,
    PM_ON   = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    PU_IDLE  = 2'd0,
    PU_DRAIN = 2'd1,
    PU_REQ   = 2'd2
  } pu_state_e;

  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;

  localparam logic [31:0] OFS_PWR   = 32'h0000_0000;
  localparam logic [31:0] OFS_CACHE = 32'h0000_0004;
  localparam logic [31:0] OFS_DLY   = 32'h0000_0008;
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cpc_regs.sv
module cpc_regs
  import cpc_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter int          DLY_W     = 16,
  parameter int          DLY_RST   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [31:0]      rdata_o,
  input  logic             ready_i,
  output pwr_mode_e        mode_o,
  output logic             en_o,
  output logic             err_o,
  output logic [DLY_W-1:0] delay_o
);
  localparam logic [31:0] A_PWR   = BASE_ADDR + OFS_PWR;
  localparam logic [31:0] A_CACHE = BASE_ADDR + OFS_CACHE;
  localparam logic [31:0] A_DLY   = BASE_ADDR + OFS_DLY;

  pwr_mode_e        mode_q, new_mode;
  logic             en_q, err_q;
  logic [DLY_W-1:0] delay_q;
  logic [31:0]      rdata_q;

  logic sel_pwr, sel_ca, sel_dly;
  logic key_ok, pwr_wr, pwr_blocked;
  logic en_ok, en_bad, err_set, err_clr;

  assign sel_pwr  = we_i && (addr_i == A_PWR);
  assign sel_ca   = we_i && (addr_i == A_CACHE);
  assign sel_dly  = we_i && (addr_i == A_DLY);
  assign key_ok   = (wdata_i[31:16] == WR_KEY);
  assign new_mode = pwr_mode_e'(wdata_i[1:0]);

  // keyed, non-reserved write; refused if it would drop power under an enabled cache
  assign pwr_wr      = sel_pwr && key_ok && (new_mode != PM_RSVD);
  assign pwr_blocked = pwr_wr && en_q && (new_mode != PM_ON);

  assign en_ok   = (mode_q == PM_ON) && ready_i;
  assign en_bad  = sel_ca && wdata_i[0] && !en_ok;
  assign err_set = en_bad || pwr_blocked;
  assign err_clr = sel_ca && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= PM_ON;
      en_q    <= 1'b0;
      err_q   <= 1'b0;
      delay_q <= DLY_W'(DLY_RST);
    end else begin
      if (pwr_wr && !pwr_blocked) mode_q <= new_mode;
      if (sel_ca) en_q <= wdata_i[0] && en_ok;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (sel_dly) delay_q <= wdata_i[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      case (addr_i)
        A_PWR:   rdata_q <= {RD_KEY, 14'd0, mode_q};
        A_CACHE: rdata_q <= {29'd0, ready_i, err_q, en_q};
        A_DLY:   rdata_q <= 32'(delay_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign mode_o  = mode_q;
  assign en_o    = en_q;
  assign err_o   = err_q;
  assign delay_o = delay_q;
endmodule

// File: rtl/cpc_pwrup_fsm.sv
module cpc_pwrup_fsm
  import cpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwr_mode_e mode_i,
  input  logic      ack_i,
  input  logic      done_i,
  output logic      req_o,
  output logic      ready_o
);
  pu_state_e state_q;
  logic      prev_on_q, ready_q, mode_on;

  assign mode_on = (mode_i == PM_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PU_IDLE;
      prev_on_q <= 1'b1;
      ready_q   <= 1'b1;
    end else begin
      prev_on_q <= mode_on;
      if (!mode_on) begin
        state_q <= PU_IDLE;
        ready_q <= 1'b0;
      end else if (!prev_on_q) begin
        state_q <= PU_DRAIN;
        ready_q <= 1'b0;
      end else begin
        case (state_q)
          // wait for the slow side to drop a previous request
          PU_DRAIN: if (!ack_i && !done_i) state_q <= PU_REQ;
          PU_REQ: if (done_i) begin
            state_q <= PU_IDLE;
            ready_q <= 1'b1;
          end
          default: state_q <= PU_IDLE;
        endcase
      end
    end
  end

  assign req_o   = (state_q == PU_REQ);
  assign ready_o = ready_q;
endmodule

// File: rtl/cpc_slow_timer.sv
module cpc_slow_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             ack_o,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             ack_q, done_q;

  // delay_i is quasi-static: software programs it before switching power on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ack_q <= req_i;
      if (!req_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (cnt_q >= delay_i) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ack_o  = ack_q;
  assign done_o = done_q;
endmodule

// File: rtl/cache_pwr_ctrl.sv
module cache_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter int          DLY_W     = 16,
  parameter int          DLY_RST   = 8
) (
  input  logic        clk_i,
  input  logic        slow_clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  output logic [1:0]  pwr_mode_o,
  output logic        sram_ready_o,
  output logic        cache_en_o,
  output logic        seq_err_o
);
  pwr_mode_e        mode;
  logic             ready, req, slow_rst_n, req_s;
  logic [DLY_W-1:0] delay;
  logic [1:0]       back_slow, back_fast;

  cpc_regs #(.BASE_ADDR(BASE_ADDR), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .ready_i(ready), .mode_o(mode), .en_o(cache_en_o), .err_o(seq_err_o),
    .delay_o(delay)
  );

  cpc_pwrup_fsm u_fsm (
    .clk_i, .rst_ni, .mode_i(mode),
    .ack_i(back_fast[1]), .done_i(back_fast[0]),
    .req_o(req), .ready_o(ready)
  );

  // reset release synchronized into the slow domain
  cpc_sync #(.W(1)) u_slow_rst (
    .clk_i(slow_clk_i), .rst_ni, .d_i(1'b1), .q_o(slow_rst_n)
  );

  cpc_sync #(.W(1)) u_req_sync (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_n), .d_i(req), .q_o(req_s)
  );

  cpc_slow_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_n), .req_i(req_s), .delay_i(delay),
    .ack_o(back_slow[1]), .done_o(back_slow[0])
  );

  cpc_sync #(.W(2)) u_back_sync (
    .clk_i, .rst_ni, .d_i(back_slow), .q_o(back_fast)
  );

  assign pwr_mode_o   = mode;
  assign sram_ready_o = ready;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] addr_i,
  input logic [15:0] key_i,
  input logic [1:0]  wmode_i,
  input logic        we_i,
  input logic [1:0]  pwr_mode_o,
  input logic        sram_ready_o,
  input logic        cache_en_o,
  input logic        seq_err_o
);
  logic pwr_wr, clr_wr;
  assign pwr_wr = we_i && (addr_i == BASE_ADDR);
  assign clr_wr = we_i && (addr_i == BASE_ADDR + 32'h4) && wmode_i[1];

  AST_KEY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_wr && (key_i != 16'h05FA) |=> $stable(pwr_mode_o)); // R2
  AST_NO_RSVD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_o != 2'd1); // R4
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_o != 2'd3 |=> !sram_ready_o); // R5
  AST_READY_ONLY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_ready_o) |-> pwr_mode_o == 2'd3); // R6
  AST_EN_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_en_o |-> sram_ready_o && pwr_mode_o == 2'd3); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o && !clr_wr |=> seq_err_o); // R8
  AST_NO_OFF_WHILE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_en_o && pwr_wr && key_i == 16'h05FA && wmode_i != 2'd3
      |=> pwr_mode_o == 2'd3 && seq_err_o); // R9
endmodule

bind cache_pwr_ctrl cpc_checker #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .key_i(wdata_i[31:16]),
  .wmode_i(wdata_i[1:0]), .we_i(we_i), .pwr_mode_o(pwr_mode_o),
  .sram_ready_o(sram_ready_o), .cache_en_o(cache_en_o), .seq_err_o(seq_err_o)
);

// File: tb/cache_pwr_ctrl_tb_top.sv
module cache_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = CLK_PERIOD * 4;

  logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  pwr_mode;
  logic        ready, en, err;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  initial begin
    #2;
    forever #(SLOW_PERIOD / 2) slow_clk = ~slow_clk;
  end

  cache_pwr_ctrl dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata),
    .pwr_mode_o(pwr_mode), .sram_ready_o(ready), .cache_en_o(en),
    .seq_err_o(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // slow cycles until ready rises
  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 200) begin
      @(posedge slow_clk);
      n++;
    end
    @(negedge clk);
  endtask

  // monitor: compare read data against scoreboard
  always @(posedge clk) rd_seen <= re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: actual 0x%08h expected none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(posedge slow_clk);

    // R1 reset state
    rd(32'h0, 32'hFA05_0003, "R1 pwr reg");
    rd(32'h4, 32'h4, "R1 cache reg");
    rd(32'h8, 32'h8, "R1 delay reg");
    chk("R1 pwr_mode_o", 32'(pwr_mode), 32'd3);
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 en/err", {30'd0, en, err}, 32'd0);

    // R2 wrong keys
    wr(32'h0, 32'h1234_0000);
    rd(32'h0, 32'hFA05_0003, "R2 bad key ignored");
    wr(32'h0, 32'hFA05_0000);
    rd(32'h0, 32'hFA05_0003, "R2 readback key not a write key");

    // R2/R3 keyed write to retained with junk in [15:2]
    wr(32'h0, 32'h05FA_FFFE);
    @(negedge clk);
    chk("R5 ready low after leaving on", 32'(ready), 32'd0);
    rd(32'h0, 32'hFA05_0002, "R3 readback format");
    chk("R2 pwr_mode_o retained", 32'(pwr_mode), 32'd2);

    // R4 reserved value ignored
    wr(32'h0, 32'h05FA_0001);
    rd(32'h0, 32'hFA05_0002, "R4 reserved ignored");

    // R8 enable while retained
    wr(32'h4, 32'h1);
    chk("R8 enable refused", 32'(en), 32'd0);
    rd(32'h4, 32'h2, "R8 error flag set");
    wr(32'h4, 32'h2);
    rd(32'h4, 32'h0, "R8 error cleared");

    // R10 delay register, R6 power-up time
    wr(32'h8, 32'h3);
    rd(32'h8, 32'h3, "R10 delay readback");
    wr(32'h0, 32'h05FA_0003);
    wait_ready(n);
    chk("R6 delay lower bound (D=3)", 32'(n >= 3), 32'd1);
    chk("R6 ready within bound (D=3)", 32'(n <= 15), 32'd1);

    // R7 enable accepted
    wr(32'h4, 32'h1);
    chk("R7 cache_en_o", 32'(en), 32'd1);
    rd(32'h4, 32'h5, "R7 cache reg");

    // R9 power down refused while enabled
    wr(32'h0, 32'h05FA_0000);
    rd(32'h0, 32'hFA05_0003, "R9 mode kept");
    rd(32'h4, 32'h7, "R9 error set");
    wr(32'h4, 32'h2);
    rd(32'h4, 32'h4, "R7 disabled and error cleared");
    wr(32'h0, 32'h05FA_0000);
    rd(32'h0, 32'hFA05_0000, "R2 off after disable");

    // R8 early enable during power-up
    wr(32'h0, 32'h05FA_0003);
    wr(32'h4, 32'h1);
    chk("R8 early enable refused", 32'(en), 32'd0);
    rd(32'h4, 32'h2, "R8 early enable error");
    wait_ready(n);
    wr(32'h4, 32'h2);
    rd(32'h4, 32'h4, "R8 cleared, ready");

    // R6 restart of an interrupted power-up
    wr(32'h0, 32'h05FA_0000);
    wr(32'h8, 32'h8);
    repeat (8) @(posedge slow_clk);
    wr(32'h0, 32'h05FA_0003);
    repeat (2) @(posedge slow_clk);
    wr(32'h0, 32'h05FA_0002);
    wr(32'h0, 32'h05FA_0003);
    wait_ready(n);
    chk("R6 restart lower bound (D=8)", 32'(n >= 8), 32'd1);
    chk("R6 restart within bound", 32'(n <= 24), 32'd1);

    // R6/R10 zero delay
    wr(32'h0, 32'h05FA_0000);
    wr(32'h8, 32'h0);
    repeat (8) @(posedge slow_clk);
    wr(32'h0, 32'h05FA_0003);
    wait_ready(n);
    chk("R6 zero delay ready", 32'(ready), 32'd1);
    chk("R6 zero delay bound", 32'(n <= 12), 32'd1);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finished = 1;
    report();
  end
endmodule